// File: doc/BRIEF.md
# In-Order Dual-Issue Floating-Point Scoreboard

This block controls issue for a small floating-point datapath that has one adder and one multiplier. A front end presents the two oldest decoded instructions that have not yet issued. Each instruction names an operation (add or multiply), a destination register and two source registers. Each cycle the block decides which of the two may leave. It never lets an instruction pass an older one that is stalled. At most one operation goes to each unit per cycle.

A per-register busy scoreboard marks every destination with a result still outstanding. Two countdown timers model the fixed unit latencies, and neither unit accepts overlapping work. When a result lands, the block raises a write-back strobe with the destination register. In that same cycle it frees the register and the unit, so a dependent instruction can issue through a same-cycle bypass. The arithmetic itself happens elsewhere. The front end pops whichever slots this block marks as issued.

Top module: `fp_issue_scoreboard`

## Requirements
- R1: After reset no register is busy, no write-back strobe is raised, and no slot issues while its valid input is low.
- R2: An add issued in cycle t raises the adder write-back strobe in cycle t+2, carrying the add's destination register.
- R3: A multiply issued in cycle t raises the multiplier write-back strobe in cycle t+5, carrying its destination register.
- R4: When the older slot holds an add and the younger slot holds a multiply (or the reverse), and neither depends on the other or on any pending register, both issue in the same cycle.
- R5: Two instructions for the same unit never issue in one cycle. The younger slot issues only in a cycle where the older slot also issues.
- R6: An instruction that reads a register with a pending write stalls. It issues in the cycle in which that register's write-back strobe is raised (same-cycle bypass), and not before.
- R7: An instruction that writes a register with a pending write stalls until the write-back cycle of the earlier write.
- R8: A unit takes no new operation while it has one in flight. The next operation to that unit can issue no earlier than the write-back cycle of the current one, so back-to-back adds are 2 cycles apart and back-to-back multiplies are 5 cycles apart.
- R9: The younger slot does not issue in the same cycle as the older slot if it reads or writes the older slot's destination register.
- R10: While the older slot is stalled, the younger slot does not issue, even if it has no hazard of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_op | input | 1 | Older slot operation: 0 = add, 1 = multiply |
| s0_dst | input | RW | Older slot destination register |
| s0_src_a | input | RW | Older slot first source register |
| s0_src_b | input | RW | Older slot second source register |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_op | input | 1 | Younger slot operation: 0 = add, 1 = multiply |
| s1_dst | input | RW | Younger slot destination register |
| s1_src_a | input | RW | Younger slot first source register |
| s1_src_b | input | RW | Younger slot second source register |
| s0_issue | output | 1 | Older slot issues this cycle |
| s1_issue | output | 1 | Younger slot issues this cycle |
| wb_add_valid | output | 1 | Adder result writes back this cycle |
| wb_add_dst | output | RW | Register written by the adder |
| wb_mul_valid | output | 1 | Multiplier result writes back this cycle |
| wb_mul_dst | output | RW | Register written by the multiplier |

## Verification
On every cycle, the assertions check these invariants: issue stays in order, each unit gets at most one operation, a write-back comes exactly the unit latency after its start, no operation starts on a unit still in flight, a write-back only clears a register that was busy, and no busy register is claimed again. The assertions also check that the younger slot never pairs with an instruction it depends on. The bench scenarios show the exact cycle each instruction leaves: the bypass issue in the write-back cycle, a pair that issues in one cycle, and an independent younger instruction held back behind a stalled older one. Only a model of the program stream can predict those cycles.

// File: rtl/fp_sb_pkg.sv
package fp_sb_pkg;
  typedef enum logic { UNIT_ADD = 1'b0, UNIT_MUL = 1'b1 } unit_e;

  // Load value for a unit countdown: result lands when the count reaches one.
  function automatic int unsigned lat_load(input int unsigned lat);
    return (lat < 1) ? 1 : lat;
  endfunction
endpackage

// File: rtl/sb_unit_timer.sv
module sb_unit_timer #(
  parameter int LAT = 2,
  parameter int RW  = 5,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] start_dst,
  output logic          ready,
  output logic          wb_valid,
  output logic [RW-1:0] wb_dst
);
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] dst_q;

  // Unit is free when idle or when its result lands this cycle.
  assign ready    = (cnt_q <= CW'(1));
  assign wb_valid = (cnt_q == CW'(1));
  assign wb_dst   = dst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dst_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(fp_sb_pkg::lat_load(LAT));
      dst_q <= start_dst;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // Independent age counter kept for the latency check.
  logic [CW:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)               age_q <= '0;
    else if (start)           age_q <= (CW+1)'(1);
    else if (wb_valid)        age_q <= '0;
    else if (age_q != '0)     age_q <= age_q + (CW+1)'(1);
  end

  // R2 for the adder instance, R3 for the multiplier instance.
  p_wb_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (age_q == (CW+1)'(LAT)));

  // R8: no start while an operation is still in flight.
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ready);
endmodule

// File: rtl/sb_busy_table.sv
module sb_busy_table #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_a_vld,
  input  logic [RW-1:0]   set_a_idx,
  input  logic            set_m_vld,
  input  logic [RW-1:0]   set_m_idx,
  input  logic            clr_a_vld,
  input  logic [RW-1:0]   clr_a_idx,
  input  logic            clr_m_vld,
  input  logic [RW-1:0]   clr_m_idx,
  output logic [NREG-1:0] busy_eff
);
  logic [NREG-1:0] busy_q, clr_mask, set_mask;

  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    if (clr_a_vld) clr_mask[clr_a_idx] = 1'b1;
    if (clr_m_vld) clr_mask[clr_m_idx] = 1'b1;
    if (set_a_vld) set_mask[set_a_idx] = 1'b1;
    if (set_m_vld) set_mask[set_m_idx] = 1'b1;
  end

  // Registers written back this cycle count as free (bypass).
  assign busy_eff = busy_q & ~clr_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_eff | set_mask;
  end

  // R6: a write-back only retires a register that was pending.
  p_clr_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_a_vld |-> busy_q[clr_a_idx]);
  p_clr_pending_mul_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_m_vld |-> busy_q[clr_m_idx]);
  // R7: a register is never claimed while an older write is still pending.
  p_set_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_a_vld |-> !busy_eff[set_a_idx]);
  p_set_free_mul_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_m_vld |-> !busy_eff[set_m_idx]);
endmodule

// File: rtl/sb_issue_pick.sv
module sb_issue_pick #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s0_valid,
  input  logic            s0_op,
  input  logic [RW-1:0]   s0_dst,
  input  logic [RW-1:0]   s0_src_a,
  input  logic [RW-1:0]   s0_src_b,
  input  logic            s1_valid,
  input  logic            s1_op,
  input  logic [RW-1:0]   s1_dst,
  input  logic [RW-1:0]   s1_src_a,
  input  logic [RW-1:0]   s1_src_b,
  input  logic [NREG-1:0] busy_eff,
  input  logic            add_ready,
  input  logic            mul_ready,
  output logic            issue0,
  output logic            issue1
);
  import fp_sb_pkg::*;

  function automatic logic regs_free(input logic [NREG-1:0] busy,
                                     input logic [RW-1:0] a,
                                     input logic [RW-1:0] b,
                                     input logic [RW-1:0] d);
    return !busy[a] && !busy[b] && !busy[d];
  endfunction

  function automatic logic touches(input logic [RW-1:0] older_dst,
                                   input logic [RW-1:0] a,
                                   input logic [RW-1:0] b,
                                   input logic [RW-1:0] d);
    return (a == older_dst) || (b == older_dst) || (d == older_dst);
  endfunction

  logic unit0_ok, unit1_ok, pair_ok;

  assign unit0_ok = (unit_e'(s0_op) == UNIT_MUL) ? mul_ready : add_ready;
  assign unit1_ok = (unit_e'(s1_op) == UNIT_MUL) ? mul_ready : add_ready;
  assign pair_ok  = (s1_op != s0_op) &&
                    !touches(s0_dst, s1_src_a, s1_src_b, s1_dst);

  assign issue0 = s0_valid && unit0_ok &&
                  regs_free(busy_eff, s0_src_a, s0_src_b, s0_dst);
  assign issue1 = issue0 && s1_valid && pair_ok && unit1_ok &&
                  regs_free(busy_eff, s1_src_a, s1_src_b, s1_dst);

  // R5 / R10: younger slot never leaves alone.
  p_inorder_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> issue0);
  // R5: a single adder and a single multiplier.
  p_one_per_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0 && issue1) |-> (s0_op != s1_op));
endmodule

// File: rtl/fp_issue_scoreboard.sv
module fp_issue_scoreboard #(
  parameter int NREG    = 32,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 5,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s0_valid,
  input  logic          s0_op,
  input  logic [RW-1:0] s0_dst,
  input  logic [RW-1:0] s0_src_a,
  input  logic [RW-1:0] s0_src_b,
  input  logic          s1_valid,
  input  logic          s1_op,
  input  logic [RW-1:0] s1_dst,
  input  logic [RW-1:0] s1_src_a,
  input  logic [RW-1:0] s1_src_b,
  output logic          s0_issue,
  output logic          s1_issue,
  output logic          wb_add_valid,
  output logic [RW-1:0] wb_add_dst,
  output logic          wb_mul_valid,
  output logic [RW-1:0] wb_mul_dst
);
  import fp_sb_pkg::*;

  logic [NREG-1:0] busy_eff;
  logic            add_ready, mul_ready;
  logic            add_start, mul_start;
  logic [RW-1:0]   add_start_dst, mul_start_dst;

  sb_issue_pick #(.NREG(NREG)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_op(s0_op), .s0_dst(s0_dst),
    .s0_src_a(s0_src_a), .s0_src_b(s0_src_b),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_dst(s1_dst),
    .s1_src_a(s1_src_a), .s1_src_b(s1_src_b),
    .busy_eff(busy_eff), .add_ready(add_ready), .mul_ready(mul_ready),
    .issue0(s0_issue), .issue1(s1_issue)
  );

  // Route issued slots to their units.
  always_comb begin
    add_start = 1'b0; add_start_dst = s0_dst;
    mul_start = 1'b0; mul_start_dst = s0_dst;
    if (s0_issue) begin
      if (unit_e'(s0_op) == UNIT_MUL) begin mul_start = 1'b1; mul_start_dst = s0_dst; end
      else                            begin add_start = 1'b1; add_start_dst = s0_dst; end
    end
    if (s1_issue) begin
      if (unit_e'(s1_op) == UNIT_MUL) begin mul_start = 1'b1; mul_start_dst = s1_dst; end
      else                            begin add_start = 1'b1; add_start_dst = s1_dst; end
    end
  end

  sb_unit_timer #(.LAT(ADD_LAT), .RW(RW)) u_add_tmr (
    .clk(clk), .rst_n(rst_n), .start(add_start), .start_dst(add_start_dst),
    .ready(add_ready), .wb_valid(wb_add_valid), .wb_dst(wb_add_dst)
  );

  sb_unit_timer #(.LAT(MUL_LAT), .RW(RW)) u_mul_tmr (
    .clk(clk), .rst_n(rst_n), .start(mul_start), .start_dst(mul_start_dst),
    .ready(mul_ready), .wb_valid(wb_mul_valid), .wb_dst(wb_mul_dst)
  );

  sb_busy_table #(.NREG(NREG)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .set_a_vld(add_start), .set_a_idx(add_start_dst),
    .set_m_vld(mul_start), .set_m_idx(mul_start_dst),
    .clr_a_vld(wb_add_valid), .clr_a_idx(wb_add_dst),
    .clr_m_vld(wb_mul_valid), .clr_m_idx(wb_mul_dst),
    .busy_eff(busy_eff)
  );

  // R9: a paired younger instruction is independent of the older one.
  p_pair_indep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_issue |-> (s1_src_a != s0_dst && s1_src_b != s0_dst && s1_dst != s0_dst));
  // R1 / R5: each unit receives at most one operation, never both slots.
  p_single_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({s0_issue, s1_issue}) <= 32'(1) + 32'(s0_op != s1_op));
endmodule

// File: tb/tb_fp_issue_scoreboard.sv
`timescale 1ns/1ps
module tb_fp_issue_scoreboard;
  localparam int RW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s0_valid = 0, s0_op = 0, s1_valid = 0, s1_op = 0;
  logic [RW-1:0] s0_dst = 0, s0_src_a = 0, s0_src_b = 0;
  logic [RW-1:0] s1_dst = 0, s1_src_a = 0, s1_src_b = 0;
  logic s0_issue, s1_issue, wb_add_valid, wb_mul_valid;
  logic [RW-1:0] wb_add_dst, wb_mul_dst;

  always #2 clk = ~clk;

  fp_issue_scoreboard dut (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_op(s0_op), .s0_dst(s0_dst),
    .s0_src_a(s0_src_a), .s0_src_b(s0_src_b),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_dst(s1_dst),
    .s1_src_a(s1_src_a), .s1_src_b(s1_src_b),
    .s0_issue(s0_issue), .s1_issue(s1_issue),
    .wb_add_valid(wb_add_valid), .wb_add_dst(wb_add_dst),
    .wb_mul_valid(wb_mul_valid), .wb_mul_dst(wb_mul_dst)
  );

  typedef struct { bit op; logic [RW-1:0] d, a, b; int exp_cyc; string req; } instr_t;
  typedef struct { int cyc; logic [RW-1:0] d; } wbexp_t;

  instr_t pend[$];
  wbexp_t qa[$], qm[$];
  int checks = 0, failures = 0, cyc = 0, total = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_instr(input bit op, input int d, input int a, input int b,
                           input int exp_cyc, input string req);
    instr_t t;
    t.op = op; t.d = RW'(d); t.a = RW'(a); t.b = RW'(b);
    t.exp_cyc = exp_cyc; t.req = req;
    pend.push_back(t);
  endtask

  // Driver: schedule expected write-back for an issued instruction.
  task automatic expect_wb(input instr_t t);
    wbexp_t e;
    e.d = t.d;
    if (t.op) begin e.cyc = cyc + 5; qm.push_back(e); end  // R3
    else      begin e.cyc = cyc + 2; qa.push_back(e); end  // R2
  endtask

  // Monitor: compare write-back strobes against the expected queues.
  task automatic watch_wb();
    wbexp_t e;
    if (wb_add_valid) begin
      if (qa.size() == 0) chk(0, "R2", "unexpected add wb dst", int'(wb_add_dst), -1);
      else begin
        e = qa.pop_front();
        chk(e.cyc == cyc, "R2", "add wb cycle", cyc, e.cyc);
        chk(e.d == wb_add_dst, "R2", "add wb dst", int'(wb_add_dst), int'(e.d));
      end
    end else if (qa.size() != 0 && qa[0].cyc <= cyc)
      chk(0, "R2", "missing add wb at cycle", cyc, qa[0].cyc);
    if (wb_mul_valid) begin
      if (qm.size() == 0) chk(0, "R3", "unexpected mul wb dst", int'(wb_mul_dst), -1);
      else begin
        e = qm.pop_front();
        chk(e.cyc == cyc, "R3", "mul wb cycle", cyc, e.cyc);
        chk(e.d == wb_mul_dst, "R3", "mul wb dst", int'(wb_mul_dst), int'(e.d));
      end
    end else if (qm.size() != 0 && qm[0].cyc <= cyc)
      chk(0, "R3", "missing mul wb at cycle", cyc, qm[0].cyc);
  endtask

  task automatic run_scenario(input string name);
    instr_t t;
    cyc = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      s0_valid = pend.size() > 0;
      s1_valid = pend.size() > 1;
      if (s0_valid) begin s0_op = pend[0].op; s0_dst = pend[0].d; s0_src_a = pend[0].a; s0_src_b = pend[0].b; end
      if (s1_valid) begin s1_op = pend[1].op; s1_dst = pend[1].d; s1_src_a = pend[1].a; s1_src_b = pend[1].b; end
      #1;
      watch_wb();
      if (s1_issue && !s0_issue) chk(0, "R10", "younger issued alone", 1, 0);
      if (s0_issue && pend.size() > 0) begin
        t = pend.pop_front();
        chk(cyc == t.exp_cyc, t.req, {name, " older issue cycle"}, cyc, t.exp_cyc);
        expect_wb(t);
        if (s1_issue && pend.size() > 0) begin
          t = pend.pop_front();
          chk(cyc == t.exp_cyc, t.req, {name, " younger issue cycle"}, cyc, t.exp_cyc);
          expect_wb(t);
        end
      end
      cyc++;
    end
    chk(pend.size() == 0, "R5", {name, " instructions left unissued"}, pend.size(), 0);
    chk(qa.size() == 0 && qm.size() == 0, "R2", {name, " write-backs outstanding"},
        qa.size() + qm.size(), 0);
  endtask

  always @(posedge clk) begin
    total++;
    if (total > 5000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<5000", total);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: clean state after reset, idle slots do not issue.
    chk(!wb_add_valid && !wb_mul_valid, "R1", "wb after reset", int'(wb_add_valid | wb_mul_valid), 0);
    chk(!s0_issue && !s1_issue, "R1", "issue with invalid slots", int'(s0_issue | s1_issue), 0);

    // R4: independent add + multiply pair in one cycle.
    add_instr(0, 1, 2, 3, 0, "R4");
    add_instr(1, 4, 5, 6, 0, "R4");
    run_scenario("pair");

    // R6 / R8 / R5: dependent add waits for bypass in the wb cycle.
    add_instr(0, 1, 2, 3, 0, "R6");
    add_instr(0, 4, 1, 5, 2, "R6");
    run_scenario("raw_add");

    // R9: add reads the multiply's destination, cannot pair; issues at mul wb.
    add_instr(1, 1, 2, 3, 0, "R9");
    add_instr(0, 2, 1, 3, 5, "R9");
    run_scenario("raw_pair");

    // R7: add to a register a pending multiply will write.
    add_instr(1, 7, 1, 2, 0, "R7");
    add_instr(0, 10, 3, 4, 0, "R4");
    add_instr(0, 7, 5, 6, 5, "R7");
    run_scenario("waw");

    // R8: back-to-back independent multiplies.
    add_instr(1, 11, 1, 2, 0, "R8");
    add_instr(1, 12, 3, 4, 5, "R8");
    run_scenario("mul_struct");

    // R10: independent multiply held behind a stalled add, then pairs.
    add_instr(0, 1, 2, 3, 0, "R10");
    add_instr(0, 2, 1, 3, 2, "R10");
    add_instr(1, 3, 4, 5, 2, "R10");
    run_scenario("inorder");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule